// File: doc/BRIEF.md
# Latched Channel Selector Controller

This block is the digital control side of a processor-programmed analog channel selector. A channel number and an on/off bit arrive from a bus. They pass into level-sensitive holding registers that follow the bus while an active-low write strobe is low and freeze on the strobe's rising edge. An active-low clear input empties the holding registers at any time. The held state is decoded into switch-drive bits. Those bits select one of eight single-ended inputs, or one of four differential pairs when the block is built in pair mode.

All pins are sampled on one system clock through synchronizer stages. The decoded selection never goes straight from one channel to another: the drive bits first drop to all-zero for a set number of cycles. A sticky timing flag records any strobe, clear, setup or hold interval that breaks its minimum, with each interval counted in clock cycles.

Top module: `chansel_ctrl`

## Requirements
- R1: During and right after the synchronous reset `rst`, `sw_on` is all-zero and `timing_err` is 0.
- R2: While `wr_n` is low and `clr_n` is high, the drive bits follow the `addr` and `en` pins after the synchronizer and gap latency.
- R3: After `wr_n` rises, later changes on `addr` and `en` have no effect on `sw_on` until the next low phase of `wr_n`.
- R4: While `clr_n` is low, `sw_on` goes to all-zero within SYNC_STAGES+2 cycles, even if `wr_n` is low.
- R5: After `clr_n` returns high, `sw_on` stays all-zero until a write loads `en` = 1.
- R6: A held `en` of 0 gives an all-zero `sw_on` for any address.
- R7: In single-ended mode (DIFF_MODE = 0) with `en` = 1, address value k turns on bit k of `sw_on` and no other bit.
- R8: In pair mode (DIFF_MODE = 1) with `en` = 1, the two low address bits k turn on bits k and k+4, and `addr[2]` is ignored.
- R9: Whenever `sw_on` moves from one non-zero value to a different one, it is all-zero for at least BBM_CYCLES cycles in between. It never changes directly between two non-zero values.
- R10: A `wr_n` low phase shorter than WR_MIN_CYC cycles, ending while `clr_n` is high, sets `timing_err`.
- R11: An `addr` or `en` change fewer than SETUP_CYC cycles before the rising edge of `wr_n` sets `timing_err`.
- R12: An `addr` or `en` change within HOLD_CYC cycles after the rising edge of `wr_n` sets `timing_err`.
- R13: A `clr_n` low pulse shorter than CLR_MIN_CYC cycles sets `timing_err`.
- R14: Once set, `timing_err` stays 1 through clears and later writes, and only `rst` returns it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Write strobe, active low: holding registers follow the bus while low |
| clr_n | input | 1 | Master clear, active low: takes priority over writes |
| addr | input | 3 | Channel number from the bus |
| en | input | 1 | Switch enable bit from the bus |
| sw_on | output | 8 | Switch-drive bits, one per switch |
| timing_err | output | 1 | Sticky flag for a broken timing rule |

## Verification
A single-ended instance and a pair-mode instance share one stimulus. Each write pattern therefore checks both decodes, and an address with bit 2 set shows whether the pair decode ignores that bit. Random writes with well-formed timing are compared against bench decode functions and must leave the timing flag clear. Directed sequences then cover several things. Bus changes after the strobe rises tell holding apart from transparency. A clear during a low strobe shows that the clear wins over the write. A single violation of each kind (short strobe, late data, early data change, short clear) shows which check raised the flag. A monitor watches every change between non-zero drive values and measures the all-zero gap.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

    localparam int CH_COUNT   = 8;
    localparam int ADDR_W     = $clog2(CH_COUNT);
    localparam int PAIR_COUNT = CH_COUNT / 2;

    // Held bus state: enable plus channel number
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } sel_t;

    localparam int SEL_W = $bits(sel_t);

    typedef enum logic {
        BBM_HOLD,
        BBM_GAP
    } bbm_state_e;

    // True when switch idx is driven by the held selection
    function automatic logic ch_hit(input sel_t s, input int idx, input bit diff);
        logic [ADDR_W-2:0] lo;
        lo = s.addr[ADDR_W-2:0];
        if (diff)
            return s.en && (int'(lo) == (idx % PAIR_COUNT));
        return s.en && (int'(s.addr) == idx);
    endfunction

endpackage

// File: rtl/chansel_sync.sv
module chansel_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/chansel_latch.sv
module chansel_latch
    import chansel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_s,
    input  logic clr_s,
    input  sel_t d_s,
    output sel_t q
);

    // Clear beats write; low strobe is transparent; high strobe holds
    always_ff @(posedge clk) begin
        if (rst || !clr_s)
            q <= '0;
        else if (!wr_s)
            q <= d_s;
    end

endmodule

// File: rtl/chansel_timing.sv
module chansel_timing
    import chansel_pkg::*;
#(
    parameter int WR_MIN_CYC  = 20,
    parameter int SETUP_CYC   = 20,
    parameter int HOLD_CYC    = 2,
    parameter int CLR_MIN_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_s,
    input  logic clr_s,
    input  sel_t d_s,
    output logic err
);

    localparam int LIM_A = (WR_MIN_CYC > SETUP_CYC) ? WR_MIN_CYC : SETUP_CYC;
    localparam int LIM   = (LIM_A > CLR_MIN_CYC) ? LIM_A : CLR_MIN_CYC;
    localparam int CW    = $clog2(LIM + 1);
    localparam int HW    = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] WR_LIM  = CW'(WR_MIN_CYC);
    localparam logic [CW-1:0] SU_LIM  = CW'(SETUP_CYC);
    localparam logic [CW-1:0] CLR_LIM = CW'(CLR_MIN_CYC);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYC - 1);

    logic          wr_q, clr_q;
    sel_t          d_q;
    logic [CW-1:0] wr_low_cnt, stable_cnt, clr_low_cnt;
    logic [HW-1:0] hold_cnt;

    logic wr_rise, clr_rise, d_chg;
    logic short_wr, short_su, hold_bad, short_clr;

    always_comb begin
        wr_rise   = wr_s && !wr_q;
        clr_rise  = clr_s && !clr_q;
        d_chg     = (d_s != d_q);
        short_wr  = wr_rise && clr_s && (wr_low_cnt < WR_LIM);
        short_su  = wr_rise && clr_s && (stable_cnt < SU_LIM);
        hold_bad  = clr_s && (wr_rise || (hold_cnt != '0)) && d_chg;
        short_clr = clr_rise && (clr_low_cnt < CLR_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q        <= 1'b1;
            clr_q       <= 1'b1;
            d_q         <= '0;
            wr_low_cnt  <= '0;
            stable_cnt  <= '0;
            clr_low_cnt <= '0;
            hold_cnt    <= '0;
            err         <= 1'b0;
        end else begin
            wr_q  <= wr_s;
            clr_q <= clr_s;
            d_q   <= d_s;
            wr_low_cnt  <= wr_s  ? '0 : ((wr_low_cnt  == '1) ? wr_low_cnt  : wr_low_cnt  + 1'b1);
            clr_low_cnt <= clr_s ? '0 : ((clr_low_cnt == '1) ? clr_low_cnt : clr_low_cnt + 1'b1);
            stable_cnt  <= d_chg ? '0 : ((stable_cnt  == '1) ? stable_cnt  : stable_cnt  + 1'b1);
            if (wr_rise)
                hold_cnt <= HOLD_LD;
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
            err <= err | short_wr | short_su | hold_bad | short_clr;
        end
    end

endmodule

// File: rtl/chansel_bbm.sv
module chansel_bbm
    import chansel_pkg::*;
#(
    parameter int W          = 8,
    parameter int BBM_CYCLES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] target,
    output logic [W-1:0] sw
);

    localparam int GW = $clog2(BBM_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LD = GW'(BBM_CYCLES - 1);

    bbm_state_e    state;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= BBM_HOLD;
            gap_cnt <= '0;
            sw      <= '0;
        end else begin
            case (state)
                BBM_HOLD: begin
                    if (target != sw) begin
                        if (sw == '0) begin
                            sw <= target;
                        end else begin
                            sw      <= '0;
                            gap_cnt <= GAP_LD;
                            state   <= BBM_GAP;
                        end
                    end
                end
                default: begin
                    if (gap_cnt == '0) begin
                        sw    <= target;
                        state <= BBM_HOLD;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/chansel_ctrl.sv
module chansel_ctrl
    import chansel_pkg::*;
#(
    parameter bit DIFF_MODE   = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int BBM_CYCLES  = 2,
    parameter int WR_MIN_CYC  = 20,
    parameter int SETUP_CYC   = 20,
    parameter int HOLD_CYC    = 2,
    parameter int CLR_MIN_CYC = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_n,
    input  logic                clr_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                en,
    output logic [CH_COUNT-1:0] sw_on,
    output logic                timing_err
);

    logic [1:0]       ctrl_s;
    logic [SEL_W-1:0] sel_raw;
    sel_t             pin_sel, sel_s, sel_held;
    logic [CH_COUNT-1:0] target;

    assign pin_sel.en   = en;
    assign pin_sel.addr = addr;

    chansel_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_ctrl_sync (
        .clk(clk), .rst(rst), .d({wr_n, clr_n}), .q(ctrl_s)
    );

    chansel_sync #(.W(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst(rst), .d(pin_sel), .q(sel_raw)
    );

    assign sel_s = sel_t'(sel_raw);

    chansel_latch u_latch (
        .clk(clk), .rst(rst), .wr_s(ctrl_s[1]), .clr_s(ctrl_s[0]),
        .d_s(sel_s), .q(sel_held)
    );

    chansel_timing #(
        .WR_MIN_CYC(WR_MIN_CYC), .SETUP_CYC(SETUP_CYC),
        .HOLD_CYC(HOLD_CYC), .CLR_MIN_CYC(CLR_MIN_CYC)
    ) u_timing (
        .clk(clk), .rst(rst), .wr_s(ctrl_s[1]), .clr_s(ctrl_s[0]),
        .d_s(sel_s), .err(timing_err)
    );

    generate
        for (genvar i = 0; i < CH_COUNT; i++) begin : g_dec
            assign target[i] = ch_hit(sel_held, i, DIFF_MODE);
        end
    endgenerate

    chansel_bbm #(.W(CH_COUNT), .BBM_CYCLES(BBM_CYCLES)) u_bbm (
        .clk(clk), .rst(rst), .target(target), .sw(sw_on)
    );

endmodule

// File: rtl/chansel_ctrl_checker.sv
module chansel_ctrl_checker
    import chansel_pkg::*;
#(
    parameter bit DIFF_MODE   = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int BBM_CYCLES  = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                clr_n,
    input logic [CH_COUNT-1:0] sw_on,
    input logic                timing_err
);

    localparam int LAT = SYNC_STAGES + 2;
    localparam int ZW  = $clog2(BBM_CYCLES + 1) + 1;
    localparam int KW  = $clog2(LAT + 1) + 1;
    localparam logic [ZW-1:0] GAP_MIN = ZW'(BBM_CYCLES);
    localparam logic [KW-1:0] CLR_LAT = KW'(LAT);

    logic [ZW-1:0]       zero_run;
    logic [KW-1:0]       clr_run;
    logic [CH_COUNT-1:0] last_nz;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_run <= '0;
            clr_run  <= '0;
            last_nz  <= '0;
        end else begin
            if (sw_on == '0)
                zero_run <= (zero_run == '1) ? zero_run : zero_run + 1'b1;
            else
                zero_run <= '0;
            if (!clr_n)
                clr_run <= (clr_run == '1) ? clr_run : clr_run + 1'b1;
            else
                clr_run <= '0;
            if (sw_on != '0)
                last_nz <= sw_on;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sw_on == '0 && !timing_err));

    assert_clear_off_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_run >= CLR_LAT) |-> (sw_on == '0));

    assert_no_direct_swap_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sw_on) != '0 && sw_on != '0) |-> (sw_on == $past(sw_on)));

    assert_gap_length_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sw_on != '0 && $past(sw_on) == '0 && last_nz != '0 && sw_on != last_nz)
        |-> (zero_run >= GAP_MIN));

    assert_flag_sticky_R14: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(timing_err)) |-> timing_err);

    generate
        if (DIFF_MODE) begin : g_pair
            assert_pair_shape_R8: assert property (@(posedge clk) disable iff (rst)
                (sw_on[PAIR_COUNT-1:0] == sw_on[CH_COUNT-1:PAIR_COUNT])
                && $onehot0(sw_on[PAIR_COUNT-1:0]));
        end else begin : g_single
            assert_single_onehot_R7: assert property (@(posedge clk) disable iff (rst)
                $countones(sw_on) <= 1);
        end
    endgenerate

endmodule

bind chansel_ctrl chansel_ctrl_checker #(
    .DIFF_MODE(DIFF_MODE), .SYNC_STAGES(SYNC_STAGES), .BBM_CYCLES(BBM_CYCLES)
) u_checker (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sw_on(sw_on), .timing_err(timing_err)
);

// File: tb/chansel_ctrl_bench.sv
`timescale 1ns/1ps
module chansel_ctrl_bench;

    localparam int BBM = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [2:0] addr = '0;
    logic       en = 1'b0;
    logic [7:0] sw_single, sw_pair;
    logic       err_single, err_pair;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    chansel_ctrl #(.DIFF_MODE(1'b0), .BBM_CYCLES(BBM)) u_chansel_ctrl (
        .clk(clk), .rst(rst), .wr_n(wr_n), .clr_n(clr_n), .addr(addr), .en(en),
        .sw_on(sw_single), .timing_err(err_single)
    );

    chansel_ctrl #(.DIFF_MODE(1'b1), .BBM_CYCLES(BBM)) u_chansel_ctrl_pair (
        .clk(clk), .rst(rst), .wr_n(wr_n), .clr_n(clr_n), .addr(addr), .en(en),
        .sw_on(sw_pair), .timing_err(err_pair)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_single(input logic [2:0] a, input logic e);
        return e ? (8'h01 << a) : 8'h00;
    endfunction

    function automatic logic [7:0] exp_pair(input logic [2:0] a, input logic e);
        return e ? (8'h11 << a[1:0]) : 8'h00;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic write_sel(input logic [2:0] a, input logic e);
        @(negedge clk);
        addr = a; en = e; wr_n = 1'b0;
        tick(25);
        wr_n = 1'b1;
        tick(25);
    endtask

    task automatic check_outs(input string req, input logic [2:0] a, input logic e);
        check({req, " single"}, sw_single, exp_single(a, e));
        check({req, " pair"},   sw_pair,   exp_pair(a, e));
    endtask

    // Break-before-make monitor on the single-ended instance (R9)
    logic [7:0] mon_prev, mon_last;
    int         mon_zero;
    always @(negedge clk) begin
        if (rst) begin
            mon_prev = '0; mon_last = '0; mon_zero = 0;
        end else begin
            if (sw_single != 8'h00) begin
                if (mon_prev != 8'h00 && sw_single != mon_prev)
                    check("R9 direct swap", sw_single, mon_prev);
                if (mon_prev == 8'h00 && mon_last != 8'h00 && sw_single != mon_last)
                    check("R9 gap cycles", (mon_zero >= BBM), 1);
                mon_last = sw_single;
                mon_zero = 0;
            end else begin
                mon_zero++;
            end
            mon_prev = sw_single;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] ra;
        logic       re;
        void'($urandom(32'd4242));
        do_reset();

        // R1: reset state
        check("R1 sw", sw_single, 0);
        check("R1 sw pair", sw_pair, 0);
        check("R1 flag", err_single, 0);

        // R6: enable 0 gives no switch
        write_sel(3'd5, 1'b0);
        check_outs("R6", 3'd5, 1'b0);

        // R7 / R8: every address
        for (int k = 0; k < 8; k++) begin
            write_sel(3'(k), 1'b1);
            check_outs("R7 R8", 3'(k), 1'b1);
        end

        // R3: bus changes after strobe rise are ignored
        write_sel(3'd3, 1'b1);
        addr = 3'd6; en = 1'b0;
        tick(20);
        check_outs("R3", 3'd3, 1'b1);

        // R2: transparent while strobe low
        wr_n = 1'b0; addr = 3'd1; en = 1'b1;
        tick(15);
        check_outs("R2", 3'd1, 1'b1);
        addr = 3'd6;
        tick(15);
        check_outs("R2", 3'd6, 1'b1);
        addr = 3'd2;
        tick(25);
        check_outs("R2", 3'd2, 1'b1);
        wr_n = 1'b1;
        tick(25);

        // Random well-formed writes (R7, R8, R6)
        for (int i = 0; i < 40; i++) begin
            ra = 3'($urandom % 8);
            re = (($urandom % 4) != 0);
            write_sel(ra, re);
            check_outs("R7 R8 R6 random", ra, re);
        end
        check("R10 no false flag", err_single, 0);
        check("R10 no false flag pair", err_pair, 0);

        // R4: clear wins over a low strobe
        write_sel(3'd4, 1'b1);
        @(negedge clk);
        wr_n = 1'b0; addr = 3'd2; en = 1'b1; clr_n = 1'b0;
        tick(10);
        check_outs("R4", 3'd0, 1'b0);
        tick(15);
        wr_n = 1'b1;
        tick(5);
        clr_n = 1'b1;
        // R5: stays off until a write with enable 1
        tick(20);
        check_outs("R5", 3'd0, 1'b0);
        write_sel(3'd2, 1'b1);
        check_outs("R5", 3'd2, 1'b1);
        check("R13 long clear no flag", err_single, 0);

        // R10: short strobe
        tick(5);
        wr_n = 1'b0;
        tick(3);
        wr_n = 1'b1;
        tick(10);
        check("R10 short strobe", err_single, 1);
        // R14: sticky through clear and write
        clr_n = 1'b0;
        tick(30);
        clr_n = 1'b1;
        tick(10);
        write_sel(3'd1, 1'b1);
        check("R14 sticky", err_single, 1);
        do_reset();
        check("R14 cleared by reset", err_single, 0);

        // R11: late data change
        @(negedge clk);
        wr_n = 1'b0; addr = 3'd1; en = 1'b1;
        tick(30);
        addr = 3'd5;
        tick(3);
        wr_n = 1'b1;
        tick(10);
        check("R11 setup", err_single, 1);
        do_reset();

        // R12: early data change after rise
        @(negedge clk);
        wr_n = 1'b0; addr = 3'd3; en = 1'b1;
        tick(25);
        wr_n = 1'b1;
        tick(1);
        addr = 3'd7;
        tick(10);
        check("R12 hold", err_single, 1);
        do_reset();
        check("R12 reset clear", err_single, 0);

        // R13: short clear pulse
        clr_n = 1'b0;
        tick(3);
        clr_n = 1'b1;
        tick(10);
        check("R13 short clear", err_single, 1);
        check("R13 short clear pair", err_pair, 1);
        do_reset();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule